// File: doc/BRIEF.md
# Interleaving Ramp Corrector

This block sits in each follower leg of a set of paralleled hysteresis-controlled inverter legs. It produces two signed offsets, one added to the upper current turn-off level and one added to the lower, so that the follower's inductor ripple settles at a fixed fraction of a switching period behind the lead leg. The lead leg's high-side and low-side turn-off events arrive as single-cycle pulses. Each pulse closes a period measurement on a free-running cycle counter. The newest measured period, whichever switch produced it, is scaled by slot/legs to give the target delay. A serial divider does this scaling.

Each offset is a straight line in time. It is zero at the desired turn-off instant, which is the target delay after the lead leg's matching edge. Its slope is the gain times the current slope of the opposite conduction interval. The gain is unsigned fixed point with 8 fractional bits. When the output voltage sits on a supply rail, a hold input forces both offsets to zero.

Top module: `ilv_ramp_corrector`

## Requirements
- R1: The target delay equals floor(P * slave_idx / n_legs), where P is the newest measured period. It is refreshed no later than CW+XW+2 clock cycles after the turn-off pulse that produced P.
- R2: A turn-off pulse on either lead switch measures P as the number of clock edges since the previous pulse of that same switch. The newest such value, from either switch, is used. If both pulses arrive in the same cycle, the high-side value wins.
- R3: Let e_hi be the number of clock edges since the last high-side pulse. Let D be the delay and K the gain code. One cycle after each edge, ramp_upper = floor(K * slope_fall * (D - e_hi) / 256).
- R4: Let e_lo be the number of clock edges since the last low-side pulse. One cycle after each edge, ramp_lower = floor(K * slope_rise * (e_lo - D) / 256).
- R5: Each offset is zero in the cycle after its elapsed count equals the delay, which is the desired turn-off instant.
- R6: While clamp_hold is high at an edge, both offsets read zero after that edge. The elapsed counts keep advancing, so the offsets resume on the ramp line as soon as the hold is released.
- R7: The elapsed counts saturate at 2^CW - 1 when no pulse arrives.
- R8: After reset both offsets are zero.
- R9: kappa is unsigned with 8 fractional bits. Code 256 means a gain of 1.0, and codes from 0 to 256 are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_hi_off | input | 1 | Pulse: lead leg high-side switch turned off |
| mst_lo_off | input | 1 | Pulse: lead leg low-side switch turned off |
| slave_idx | input | XW | This leg's slot, 1 to n_legs-1 |
| n_legs | input | NW | Number of paralleled legs |
| slope_rise | input | SW | Current rise per cycle while high side conducts |
| slope_fall | input | SW | Current fall per cycle while low side conducts |
| kappa | input | KW | Convergence gain, 8 fractional bits |
| clamp_hold | input | 1 | Output voltage clamped: force offsets to zero |
| ramp_upper | output | RW | Signed offset for the upper turn-off level |
| ramp_lower | output | RW | Signed offset for the lower turn-off level |

## Verification
The assertions assume the following about the inputs:
- Turn-off pulses last a single cycle.
- slave_idx is at least 1 and below n_legs.
- kappa never exceeds 256.

The delay-bound check depends on the slot lying below the leg count. The stimulus respects these conditions by sweeping legs from 2 to 5, every slot from 1 to legs-1, and gain codes up to exactly 256. Pulses are always driven one cycle wide, with periods well above the divider latency. The bench compares the ramps only after two full periods under a new setting, or after a settling window that follows a change of the newest period.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int IlvKFrac = 8;

  typedef enum logic {
    DV_IDLE = 1'b0,
    DV_RUN  = 1'b1
  } ilv_div_st_e;
endpackage

// File: rtl/ilv_period_meter.sv
module ilv_period_meter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hi_evt,
  input  logic          lo_evt,
  output logic [CW-1:0] period_q,
  output logic          new_q
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] st_hi_q, st_hi_d;
  logic [CW-1:0] st_lo_q, st_lo_d;
  logic [CW-1:0] period_d;
  logic          new_d;

  always_comb begin
    cnt_d    = cnt_q + 1'b1;
    st_hi_d  = st_hi_q;
    st_lo_d  = st_lo_q;
    period_d = period_q;
    new_d    = 1'b0;
    if (lo_evt) begin
      st_lo_d  = cnt_q;
      period_d = cnt_q - st_lo_q;
      new_d    = 1'b1;
    end
    if (hi_evt) begin
      st_hi_d  = cnt_q;
      period_d = cnt_q - st_hi_q;
      new_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      st_hi_q  <= '0;
      st_lo_q  <= '0;
      period_q <= '0;
      new_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      st_hi_q  <= st_hi_d;
      st_lo_q  <= st_lo_d;
      period_q <= period_d;
      new_q    <= new_d;
    end
  end

  // R2: every turn-off pulse yields a fresh period flag one cycle later
  p_new_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_evt || lo_evt) |=> new_q);
  p_no_new_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_evt || lo_evt) |=> !new_q);
endmodule

// File: rtl/ilv_delay_div.sv
module ilv_delay_div
  import ilv_pkg::*;
#(
  parameter int CW = 16,
  parameter int XW = 4,
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] tsw,
  input  logic [XW-1:0] idx,
  input  logic [NW-1:0] nmod,
  output logic [CW-1:0] delay_q
);
  localparam int DW  = CW + XW;
  localparam int STW = $clog2(DW);
  localparam logic [STW-1:0] StepLast = STW'(DW - 1);

  ilv_div_st_e   st_q, st_d;
  logic [STW-1:0] step_q, step_d;
  logic [DW-1:0] quo_q, quo_d, quo_n;
  logic [NW-1:0] rem_q, rem_d, rem_n;
  logic [NW-1:0] dvs_q, dvs_d;
  logic [CW-1:0] lat_q, lat_d;
  logic [CW-1:0] delay_d;
  logic [NW:0]   rem_sh;
  logic          ge;

  always_comb begin
    st_d    = st_q;
    step_d  = step_q;
    quo_d   = quo_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    lat_d   = lat_q;
    delay_d = delay_q;
    rem_sh  = {rem_q, quo_q[DW-1]};
    ge      = (rem_sh >= {1'b0, dvs_q});
    rem_n   = ge ? NW'(rem_sh - {1'b0, dvs_q}) : NW'(rem_sh);
    quo_n   = {quo_q[DW-2:0], ge};
    if (start) begin
      st_d   = DV_RUN;
      step_d = '0;
      quo_d  = DW'(tsw) * DW'(idx);
      rem_d  = '0;
      dvs_d  = nmod;
      lat_d  = tsw;
    end else if (st_q == DV_RUN) begin
      quo_d  = quo_n;
      rem_d  = rem_n;
      step_d = step_q + 1'b1;
      if (step_q == StepLast) begin
        st_d    = DV_IDLE;
        delay_d = quo_n[CW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= DV_IDLE;
      step_q  <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      lat_q   <= '0;
      delay_q <= '0;
    end else begin
      st_q    <= st_d;
      step_q  <= step_d;
      quo_q   <= quo_d;
      rem_q   <= rem_d;
      dvs_q   <= dvs_d;
      lat_q   <= lat_d;
      delay_q <= delay_d;
    end
  end

  // R1: with slot below leg count, the settled delay never exceeds the period it came from
  p_delay_in_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == DV_IDLE) |-> (delay_q <= lat_q));
endmodule

// File: rtl/ilv_ramp_gen.sv
module ilv_ramp_gen
  import ilv_pkg::*;
#(
  parameter int CW      = 16,
  parameter int SW      = 10,
  parameter int KW      = 9,
  parameter bit DESCEND = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt,
  input  logic                 dis,
  input  logic [SW-1:0]        slope,
  input  logic [KW-1:0]        kappa,
  input  logic [CW-1:0]        delay,
  output logic signed [CW+SW+KW-IlvKFrac:0] ramp_q
);
  localparam int PW = CW + SW + KW + 1;
  localparam int RW = PW - IlvKFrac;
  localparam logic [CW-1:0] ElMax = '1;

  logic [CW-1:0]        el_q, el_d;
  logic signed [CW:0]   err;
  logic signed [PW-1:0] prod;
  logic signed [RW-1:0] ramp_d;

  always_comb begin
    if (evt)              el_d = '0;
    else if (el_q != ElMax) el_d = el_q + 1'b1;
    else                  el_d = el_q;
  end

  generate
    if (DESCEND) begin : g_desc
      assign err = $signed({1'b0, delay}) - $signed({1'b0, el_q});
    end else begin : g_asc
      assign err = $signed({1'b0, el_q}) - $signed({1'b0, delay});
    end
  endgenerate

  always_comb begin
    prod   = PW'(err) * PW'($signed({1'b0, slope})) * PW'($signed({1'b0, kappa}));
    ramp_d = dis ? '0 : RW'(prod >>> IlvKFrac);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      el_q   <= '0;
      ramp_q <= '0;
    end else begin
      el_q   <= el_d;
      ramp_q <= ramp_d;
    end
  end

  // R3/R4: the lead edge restarts the time origin of the ramp
  p_edge_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (el_q == '0));
  // R5: zero crossing at the desired turn-off instant
  p_zero_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis && el_q == delay) |=> (ramp_q == '0));
  // R6: clamp hold silences the offset
  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (ramp_q == '0));
  // R7: elapsed count sticks at its ceiling
  p_el_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && el_q == ElMax) |=> (el_q == ElMax));
endmodule

// File: rtl/ilv_ramp_corrector.sv
module ilv_ramp_corrector
  import ilv_pkg::*;
#(
  parameter int CW = 16,
  parameter int XW = 4,
  parameter int NW = 5,
  parameter int SW = 10,
  parameter int KW = 9,
  localparam int RW = CW + SW + KW + 1 - IlvKFrac
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mst_hi_off,
  input  logic                 mst_lo_off,
  input  logic [XW-1:0]        slave_idx,
  input  logic [NW-1:0]        n_legs,
  input  logic [SW-1:0]        slope_rise,
  input  logic [SW-1:0]        slope_fall,
  input  logic [KW-1:0]        kappa,
  input  logic                 clamp_hold,
  output logic signed [RW-1:0] ramp_upper,
  output logic signed [RW-1:0] ramp_lower
);
  logic [CW-1:0]        period;
  logic                 period_new;
  logic [CW-1:0]        delay;
  logic [1:0]           evt_v;
  logic [SW-1:0]        slope_v [2];
  logic signed [RW-1:0] ramp_v  [2];

  assign evt_v      = {mst_lo_off, mst_hi_off};
  assign slope_v[0] = slope_fall;
  assign slope_v[1] = slope_rise;

  ilv_period_meter #(.CW(CW)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_evt   (mst_hi_off),
    .lo_evt   (mst_lo_off),
    .period_q (period),
    .new_q    (period_new)
  );

  ilv_delay_div #(.CW(CW), .XW(XW), .NW(NW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (period_new),
    .tsw     (period),
    .idx     (slave_idx),
    .nmod    (n_legs),
    .delay_q (delay)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ramp
    ilv_ramp_gen #(.CW(CW), .SW(SW), .KW(KW), .DESCEND(g == 0)) u_rg (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_v[g]),
      .dis    (clamp_hold),
      .slope  (slope_v[g]),
      .kappa  (kappa),
      .delay  (delay),
      .ramp_q (ramp_v[g])
    );
  end

  assign ramp_upper = ramp_v[0];
  assign ramp_lower = ramp_v[1];

  // R9: gain code stays within 0..1.0
  p_kappa_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    kappa <= KW'(1 << IlvKFrac));
endmodule

// File: tb/sim_ilv_ramp_corrector.sv
module sim_ilv_ramp_corrector;
  localparam int CW = 8, XW = 3, NW = 4, SW = 6, KW = 9;
  localparam int RW = CW + SW + KW + 1 - 8;
  localparam int EMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mst_hi_off = 1'b0, mst_lo_off = 1'b0, clamp_hold = 1'b0;
  logic [XW-1:0] slave_idx = 3'd1;
  logic [NW-1:0] n_legs = 4'd2;
  logic [SW-1:0] slope_rise = '0, slope_fall = '0;
  logic [KW-1:0] kappa = '0;
  logic signed [RW-1:0] ramp_upper, ramp_lower;

  int n_chk = 0, n_fail = 0;
  int e_hi = 0, e_lo = 0, exp_delay = 0;
  bit chk_on = 1'b0;
  string tag = "R8";

  always #10 clk = ~clk;

  ilv_ramp_corrector #(.CW(CW), .XW(XW), .NW(NW), .SW(SW), .KW(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .mst_hi_off(mst_hi_off), .mst_lo_off(mst_lo_off),
    .slave_idx(slave_idx), .n_legs(n_legs), .slope_rise(slope_rise),
    .slope_fall(slope_fall), .kappa(kappa), .clamp_hold(clamp_hold),
    .ramp_upper(ramp_upper), .ramp_lower(ramp_lower));

  task automatic chk(input string t, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", t, act, exp);
    end
  endtask

  function automatic longint up_exp(int e, int d);
    return ((longint'(d) - longint'(e)) * longint'(slope_fall) * longint'(kappa)) >>> 8;
  endfunction
  function automatic longint lo_exp(int e, int d);
    return ((longint'(e) - longint'(d)) * longint'(slope_rise) * longint'(kappa)) >>> 8;
  endfunction

  task automatic tick(input bit hi, input bit lo, input bit dis);
    longint eu, el;
    bit zu, zl;
    mst_hi_off = hi; mst_lo_off = lo; clamp_hold = dis;
    @(posedge clk);
    eu = dis ? 0 : up_exp(e_hi, exp_delay);
    el = dis ? 0 : lo_exp(e_lo, exp_delay);
    zu = !dis && (e_hi == exp_delay);
    zl = !dis && (e_lo == exp_delay);
    e_hi = hi ? 0 : ((e_hi < EMAX) ? e_hi + 1 : e_hi);
    e_lo = lo ? 0 : ((e_lo < EMAX) ? e_lo + 1 : e_lo);
    @(negedge clk);
    if (chk_on) begin
      chk({tag, " R3 upper"}, longint'(ramp_upper), eu);
      chk({tag, " R4 lower"}, longint'(ramp_lower), el);
      if (zu) chk("R5 upper crossing", longint'(ramp_upper), 0);
      if (zl) chk("R5 lower crossing", longint'(ramp_lower), 0);
    end
  endtask

  task automatic run_period(input int p, input bit check, input int da, input int db);
    chk_on = check;
    for (int c = 0; c < p; c++) tick(c == 0, c == p / 2, (c >= da) && (c < db));
    chk_on = 1'b0;
  endtask

  task automatic setup(input int n, input int x, input int k, input int sr, input int sf, input int p);
    n_legs = NW'(n); slave_idx = XW'(x); kappa = KW'(k);
    slope_rise = SW'(sr); slope_fall = SW'(sf);
    exp_delay = (p * x) / n;
    run_period(p, 1'b0, 0, 0);
    run_period(p, 1'b0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int kl[4];
    kl[0] = 0; kl[1] = 64; kl[2] = 200; kl[3] = 256;
    repeat (3) @(negedge clk);
    chk("R8 reset upper", longint'(ramp_upper), 0);
    chk("R8 reset lower", longint'(ramp_lower), 0);
    rst_n = 1'b1;
    chk_on = 1'b1; tag = "R8";
    repeat (4) tick(0, 0, 0);
    chk_on = 1'b0;

    // R1/R3/R4/R9 sweep over legs, slots and gains
    tag = "R1 R9 sweep";
    for (int n = 2; n <= 5; n++)
      for (int x = 1; x < n; x++)
        for (int ki = 0; ki < 4; ki++) begin
          setup(n, x, kl[ki], 3 + x + ki, 9 - x + n, 30 + 2 * n + x);
          run_period(30 + 2 * n + x, 1'b1, 0, 0);
        end

    // R6 clamp hold window
    tag = "R6 hold";
    setup(3, 1, 128, 11, 13, 36);
    run_period(36, 1'b1, 4, 14);
    run_period(36, 1'b1, 16, 25);

    // R2 newest period from the low-side edge
    tag = "R2 newest";
    setup(5, 2, 256, 7, 5, 40);
    chk_on = 1'b1;
    tick(1, 0, 0);
    for (int c = 1; c < 76; c++) tick(0, c == 20, 0);
    tick(0, 1, 0);
    chk_on = 1'b0;
    for (int c = 0; c < 16; c++) tick(0, 0, 0);
    exp_delay = (56 * 2) / 5;
    chk_on = 1'b1;
    for (int c = 0; c < 40; c++) tick(0, 0, 0);
    chk_on = 1'b0;

    // R7 elapsed saturation
    tag = "R7 saturate";
    setup(5, 2, 256, 7, 5, 40);
    run_period(40, 1'b1, 0, 0);
    chk_on = 1'b1;
    for (int c = 0; c < 300; c++) tick(0, 0, 0);
    chk_on = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule